// File: doc/BRIEF.md
# Ring Interrupt Command Unit

This block handles remote interrupts for one node of a ring network in which every node keeps a copy of shared memory. On the local side, software writes one send register. That write builds a single interrupt command frame. The frame names one of three channels and either one target node or, through a broadcast flag, every node. The frame always carries this node's strapped identity as its originator. The frame leaves through a valid/ready port. It is held back while earlier data transfers from this node are still waiting to go out, so the receivers see the data before the interrupt.

On the receive side, the block looks at every interrupt command that passes by on the ring. A command is accepted when it is meant for this node and its channel is armed. The originator's identity is then queued in that channel's FIFO, and the channel's request line stays high for as long as entries remain. Software reads a pop register to take the oldest originator. Each channel also keeps a vector and a level register, which are driven out to the interrupt logic of the host bus.

Top module: `ring_irq_cmd`

## Requirements
- R1: After reset, `irq_o` is 0, `cmd_valid_o` is 0, `reg_rdata_o` is 0, all configuration is 0, and all FIFOs are empty.
- R2: A write to the send register (address 0) with a channel other than 3 loads one pending command. The write data carries the target in bits 7:0, the channel in bits 9:8 and the broadcast flag in bit 11. The frame on `cmd_frame_o` is laid out as originator in bits 7:0 (equal to `node_id_i`), target in bits 15:8, channel in bits 17:16 and broadcast in bit 18.
- R3: A pending command appears on `cmd_valid_o` only while `data_pend_i` is low. The frame stays unchanged until a cycle in which `cmd_valid_o` and `cmd_ready_i` are both high, and the pending state clears at that edge.
- R4: A send write made while a command is pending, or one that names channel 3, has no effect.
- R5: A received frame is accepted when all of these hold: `rx_valid_i` and `rx_is_irq_i` are high, the channel is below 3, the broadcast bit is set or the target equals `node_id_i`, and the channel is enabled. Its originator is queued, and that channel's `irq_o` bit is high after the edge that samples the frame.
- R6: The block ignores received frames that are not interrupt commands, that carry another target without the broadcast bit, that name channel 3, or whose originator equals `node_id_i`.
- R7: A channel is enabled only when its arm bit (config bit 11) is 1 and its level (config bits 10:8) is nonzero. A frame for a channel that is not enabled is dropped, sets no overflow and raises no request.
- R8: A read of address 4+c pops channel c in FIFO order. The read data appears on `reg_rdata_o` after the edge and is {bit 8 = 1, bits 7:0 = originator}. A pop read of an empty FIFO returns 0. `irq_o[c]` falls once the last entry has been popped.
- R9: When a channel's FIFO already holds FIFO_DEPTH entries, an accepted frame is dropped and the sticky overflow bit c (status bit 8+c) is set. Writing 1 to that bit of the status register (address 7) clears it.
- R10: Reading the status register (address 7) returns `node_id_i` in bits 7:0, the overflow bits in bits 10:8 and the pending-command flag in bit 11.
- R11: Writing config register 1+c stores vector bits 7:0, level bits 10:8 and arm bit 11. Reading that register returns the same value. The vector and level are driven on `irq_vec_o` and `irq_lvl_o` in slice c.
- R12: Each channel queues, requests and overflows independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id_i | input | 8 | Static strap giving this node's identity |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on a pop address) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Registered read data, valid the cycle after the strobe |
| data_pend_i | input | 1 | Earlier data transfers from this node are still queued |
| cmd_valid_o | output | 1 | Interrupt command frame offered to the transmit path |
| cmd_ready_i | input | 1 | Transmit path takes the frame |
| cmd_frame_o | output | 19 | Outgoing command frame |
| rx_valid_i | input | 1 | A received frame is present |
| rx_is_irq_i | input | 1 | The received frame is an interrupt command |
| rx_frame_i | input | 19 | Received frame |
| irq_o | output | 3 | Per-channel interrupt request |
| irq_vec_o | output | 24 | Per-channel vector, 8 bits each |
| irq_lvl_o | output | 9 | Per-channel level, 3 bits each |

## Verification
A FIFO pointer or count that goes wrong shows up as soon as the next pop read returns. The read gives back an originator out of order, a valid entry after the queue should be empty, or a zero while `irq_o` is still high. A corrupted overflow or enable state shows up in the next status read, or as a request line that fails to rise in the cycle after an accepted frame. A lost or changed pending command shows up at once on `cmd_valid_o` and `cmd_frame_o`, or in the status pending bit, when `data_pend_i` falls or the handshake completes.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
    localparam int ID_W    = 8;
    localparam int NUM_CH  = 3;
    localparam int CH_W    = 2;
    localparam int VEC_W   = 8;
    localparam int LVL_W   = 3;
    localparam int REG_W   = 12;
    localparam int AD_W    = 3;
    localparam int FRAME_W = 1 + CH_W + 2 * ID_W;

    // frame on the ring: bcast | chan | target | origin
    typedef struct packed {
        logic            bcast;
        logic [CH_W-1:0] chan;
        logic [ID_W-1:0] target;
        logic [ID_W-1:0] origin;
    } irq_cmd_t;

    // matches the config register layout
    typedef struct packed {
        logic             arm;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } chan_cfg_t;

    localparam logic [AD_W-1:0] A_SEND = 3'd0;
    localparam logic [AD_W-1:0] A_CFG0 = 3'd1;
    localparam logic [AD_W-1:0] A_POP0 = 3'd4;
    localparam logic [AD_W-1:0] A_STAT = 3'd7;
endpackage

// File: rtl/ring_irq_fifo.sv
module ring_irq_fifo #(
    parameter int DEPTH = 512,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= din_i;
    end
endmodule

// File: rtl/ring_irq_rx_match.sv
module ring_irq_rx_match
    import ring_irq_pkg::*;
(
    input  logic               valid_i,
    input  logic               is_irq_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [ID_W-1:0]    node_id_i,
    input  logic [NUM_CH-1:0]  en_i,
    output logic [NUM_CH-1:0]  hit_o
);
    irq_cmd_t f;
    logic     for_me;

    assign f      = irq_cmd_t'(frame_i);
    assign for_me = valid_i && is_irq_i && (f.origin != node_id_i)
                    && (f.bcast || (f.target == node_id_i));

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            hit_o[c] = for_me && en_i[c] && (f.chan == CH_W'(c));
        end
    end
endmodule

// File: rtl/ring_irq_cmd.sv
module ring_irq_cmd
    import ring_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ID_W-1:0]           node_id_i,
    input  logic                      reg_wr_i,
    input  logic                      reg_rd_i,
    input  logic [AD_W-1:0]           reg_addr_i,
    input  logic [REG_W-1:0]          reg_wdata_i,
    output logic [REG_W-1:0]          reg_rdata_o,
    input  logic                      data_pend_i,
    output logic                      cmd_valid_o,
    input  logic                      cmd_ready_i,
    output logic [FRAME_W-1:0]        cmd_frame_o,
    input  logic                      rx_valid_i,
    input  logic                      rx_is_irq_i,
    input  logic [FRAME_W-1:0]        rx_frame_i,
    output logic [NUM_CH-1:0]         irq_o,
    output logic [NUM_CH*VEC_W-1:0]   irq_vec_o,
    output logic [NUM_CH*LVL_W-1:0]   irq_lvl_o
);
    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]      ovf;
        logic                   pend;
        irq_cmd_t               slot;
        logic [REG_W-1:0]       rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CH-1:0] en_w, hit_w, push_w, pop_w, full_w, empty_w;
    logic [ID_W-1:0]   head_w [NUM_CH];
    logic [CH_W-1:0]   send_chan;
    logic              send_ok;

    // channel enable and bus-side outputs
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            en_w[c] = st_q.cfg[c].arm && (st_q.cfg[c].lvl != '0);
            irq_o[c] = en_w[c] && !empty_w[c];
            irq_vec_o[c*VEC_W +: VEC_W] = st_q.cfg[c].vec;
            irq_lvl_o[c*LVL_W +: LVL_W] = st_q.cfg[c].lvl;
            pop_w[c] = reg_rd_i && (reg_addr_i == AD_W'(int'(A_POP0) + c)) && !empty_w[c];
            push_w[c] = hit_w[c] && !full_w[c];
        end
    end

    ring_irq_rx_match u_match (
        .valid_i   (rx_valid_i),
        .is_irq_i  (rx_is_irq_i),
        .frame_i   (rx_frame_i),
        .node_id_i (node_id_i),
        .en_i      (en_w),
        .hit_o     (hit_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ring_irq_fifo #(.DEPTH(FIFO_DEPTH), .W(ID_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push_w[g]),
            .din_i   (rx_frame_i[ID_W-1:0]),
            .pop_i   (pop_w[g]),
            .head_o  (head_w[g]),
            .full_o  (full_w[g]),
            .empty_o (empty_w[g])
        );
    end

    assign send_chan   = reg_wdata_i[9:8];
    assign send_ok     = reg_wr_i && (reg_addr_i == A_SEND) && !st_q.pend
                         && (int'(send_chan) < NUM_CH);
    assign cmd_valid_o = st_q.pend && !data_pend_i;
    assign cmd_frame_o = st_q.slot;
    assign reg_rdata_o = st_q.rdata;

    always_comb begin
        st_d = st_q;

        // outgoing command slot
        if (cmd_valid_o && cmd_ready_i) st_d.pend = 1'b0;
        if (send_ok) begin
            st_d.pend         = 1'b1;
            st_d.slot.bcast   = reg_wdata_i[11];
            st_d.slot.chan    = send_chan;
            st_d.slot.target  = reg_wdata_i[7:0];
            st_d.slot.origin  = node_id_i;
        end

        // configuration, overflow clear and set
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_wr_i && (reg_addr_i == AD_W'(int'(A_CFG0) + c)))
                st_d.cfg[c] = chan_cfg_t'(reg_wdata_i);
            if (reg_wr_i && (reg_addr_i == A_STAT) && reg_wdata_i[8+c])
                st_d.ovf[c] = 1'b0;
            if (hit_w[c] && full_w[c])
                st_d.ovf[c] = 1'b1;
        end

        // read data
        if (reg_rd_i) begin
            st_d.rdata = '0;
            if (reg_addr_i == A_STAT)
                st_d.rdata = {st_q.pend, st_q.ovf, node_id_i};
            for (int c = 0; c < NUM_CH; c++) begin
                if (reg_addr_i == AD_W'(int'(A_CFG0) + c))
                    st_d.rdata = REG_W'(st_q.cfg[c]);
                if (pop_w[c])
                    st_d.rdata = REG_W'({1'b1, head_w[c]});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ring_irq_cmd_chk.sv
module ring_irq_cmd_chk
    import ring_irq_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [ID_W-1:0]           node_id_i,
    input logic                      reg_wr_i,
    input logic                      data_pend_i,
    input logic                      cmd_valid_o,
    input logic                      cmd_ready_i,
    input logic [FRAME_W-1:0]        cmd_frame_o,
    input logic                      rx_valid_i,
    input logic [FRAME_W-1:0]        rx_frame_i,
    input logic [NUM_CH-1:0]         irq_o,
    input logic [NUM_CH-1:0]         push_w
);
    a_r3_wait_data: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !data_pend_i);

    a_r3_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> $stable(cmd_frame_o));

    a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_frame_o[ID_W-1:0] == node_id_i));

    a_r6_own_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && (rx_frame_i[ID_W-1:0] == node_id_i)) |-> (push_w == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        a_r5_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (push_w[g] && !reg_wr_i) |=> irq_o[g]);
    end
endmodule

bind ring_irq_cmd ring_irq_cmd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .node_id_i   (node_id_i),
    .reg_wr_i    (reg_wr_i),
    .data_pend_i (data_pend_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_frame_o (cmd_frame_o),
    .rx_valid_i  (rx_valid_i),
    .rx_frame_i  (rx_frame_i),
    .irq_o       (irq_o),
    .push_w      (push_w)
);

// File: tb/ring_irq_cmd_tb.sv
module ring_irq_cmd_tb;
    import ring_irq_pkg::*;

    localparam int DEPTH = 512;
    localparam logic [7:0] MY_ID = 8'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic data_pend = 1'b0;
    logic cmd_valid, cmd_ready = 1'b0;
    logic [18:0] cmd_frame;
    logic rx_valid = 1'b0, rx_is_irq = 1'b0;
    logic [18:0] rx_frame = '0;
    logic [2:0] irq;
    logic [23:0] irq_vec;
    logic [8:0] irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ring_irq_cmd #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .node_id_i(MY_ID),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .data_pend_i(data_pend), .cmd_valid_o(cmd_valid),
        .cmd_ready_i(cmd_ready), .cmd_frame_o(cmd_frame),
        .rx_valid_i(rx_valid), .rx_is_irq_i(rx_is_irq), .rx_frame_i(rx_frame),
        .irq_o(irq), .irq_vec_o(irq_vec), .irq_lvl_o(irq_lvl)
    );

    function automatic logic [18:0] mk(input logic b, input logic [1:0] ch,
                                       input logic [7:0] tgt, input logic [7:0] org);
        return {b, ch, tgt, org};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic rx(input logic [18:0] f, input logic is_irq);
        @(negedge clk); rx_valid = 1'b1; rx_is_irq = is_irq; rx_frame = f;
        @(negedge clk); rx_valid = 1'b0; rx_is_irq = 1'b0;
    endtask

    task automatic handshake();
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [11:0] d;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cmd_valid", 32'(cmd_valid), 0);
        chk("R1 rdata", 32'(reg_rdata), 0);
        chk("R1 vec", 32'(irq_vec), 0);
        rd(A_STAT, d);
        chk("R10 status after reset", 32'(d), 32'h02A);
    endtask

    task automatic t_config();
        logic [11:0] d;
        wr(3'd1, 12'hB40);   // ch0 arm, lvl 3, vec 40
        wr(3'd2, 12'hD51);   // ch1 arm, lvl 5, vec 51
        wr(3'd3, 12'h262);   // ch2 not armed, lvl 2, vec 62
        rd(3'd1, d);
        chk("R11 cfg0 readback", 32'(d), 32'hB40);
        rd(3'd3, d);
        chk("R11 cfg2 readback", 32'(d), 32'h262);
        chk("R11 vec out", 32'(irq_vec), 32'h625140);
        chk("R11 lvl out", 32'(irq_lvl), {23'b0, 3'd2, 3'd5, 3'd3});
    endtask

    task automatic t_send();
        logic [11:0] d;
        data_pend = 1'b1;
        wr(A_SEND, 12'h105);          // target 05, chan 1
        chk("R3 held by data", 32'(cmd_valid), 0);
        rd(A_STAT, d);
        chk("R10 pending bit", 32'(d), 32'h82A);
        wr(A_SEND, 12'h2FF);          // ignored: pending
        @(negedge clk); data_pend = 1'b0;
        #1;
        chk("R3 valid after data", 32'(cmd_valid), 1);
        chk("R2 frame unicast", 32'(cmd_frame), 32'(mk(1'b0, 2'd1, 8'h05, MY_ID)));
        @(negedge clk);
        chk("R4 frame kept while pending", 32'(cmd_frame), 32'(mk(1'b0, 2'd1, 8'h05, MY_ID)));
        handshake();
        chk("R3 slot cleared", 32'(cmd_valid), 0);
        wr(A_SEND, 12'hA00);          // bcast, chan 2
        chk("R2 frame broadcast", 32'(cmd_frame), 32'(mk(1'b1, 2'd2, 8'h00, MY_ID)));
        chk("R2 bcast valid", 32'(cmd_valid), 1);
        handshake();
        wr(A_SEND, 12'h311);          // chan 3: ignored
        chk("R4 chan3 send ignored", 32'(cmd_valid), 0);
        rd(A_STAT, d);
        chk("R4 no pending after chan3", 32'(d), 32'h02A);
    endtask

    task automatic t_receive();
        logic [11:0] d;
        rx(mk(1'b0, 2'd0, MY_ID, 8'h11), 1'b1);
        chk("R5 irq0 raised", 32'(irq), 32'b001);
        rd(3'd4, d);
        chk("R8 pop ch0", 32'(d), 32'h111);
        chk("R8 irq0 falls", 32'(irq), 0);
        rd(3'd4, d);
        chk("R8 empty pop", 32'(d), 0);
        rx(mk(1'b0, 2'd1, MY_ID, 8'h21), 1'b1);
        rx(mk(1'b0, 2'd1, MY_ID, 8'h22), 1'b1);
        rx(mk(1'b1, 2'd1, 8'h99, 8'h33), 1'b1);
        chk("R12 only ch1 requests", 32'(irq), 32'b010);
        rd(3'd5, d); chk("R8 order 1", 32'(d), 32'h121);
        rd(3'd5, d); chk("R8 order 2", 32'(d), 32'h122);
        rd(3'd5, d); chk("R5 broadcast queued", 32'(d), 32'h133);
        chk("R8 irq1 falls", 32'(irq), 0);
    endtask

    task automatic t_ignore();
        logic [11:0] d;
        rx(mk(1'b0, 2'd0, 8'h07, 8'h11), 1'b1);   // other target
        rx(mk(1'b0, 2'd0, MY_ID, 8'h12), 1'b0);   // data frame
        rx(mk(1'b1, 2'd0, MY_ID, MY_ID), 1'b1);   // own origin
        rx(mk(1'b0, 2'd3, MY_ID, 8'h13), 1'b1);   // channel 3
        chk("R6 no request", 32'(irq), 0);
        rd(3'd4, d);
        chk("R6 nothing queued", 32'(d), 0);
        rx(mk(1'b0, 2'd2, MY_ID, 8'h44), 1'b1);   // ch2 not armed
        chk("R7 unarmed no irq", 32'(irq), 0);
        rd(3'd6, d);
        chk("R7 unarmed not queued", 32'(d), 0);
        wr(3'd3, 12'h862);                        // armed, level 0
        rx(mk(1'b0, 2'd2, MY_ID, 8'h45), 1'b1);
        rd(3'd6, d);
        chk("R7 level zero dropped", 32'(d), 0);
        rd(A_STAT, d);
        chk("R7 no overflow flag", 32'(d), 32'h02A);
        wr(3'd3, 12'hA62);                        // armed, level 2
        rx(mk(1'b0, 2'd2, MY_ID, 8'h46), 1'b1);
        chk("R7 enabled accepts", 32'(irq), 32'b100);
        rd(3'd6, d);
        chk("R7 enabled entry", 32'(d), 32'h146);
    endtask

    task automatic t_overflow();
        logic [11:0] d;
        for (int i = 0; i < DEPTH; i++)
            rx(mk(1'b0, 2'd0, MY_ID, 8'(8'h80 + (i % 64))), 1'b1);
        rd(A_STAT, d);
        chk("R9 full, no overflow yet", 32'(d), 32'h02A);
        rx(mk(1'b0, 2'd0, MY_ID, 8'h7F), 1'b1);
        rx(mk(1'b0, 2'd1, MY_ID, 8'h55), 1'b1);
        rd(A_STAT, d);
        chk("R9 overflow set ch0 only", 32'(d), 32'h12A);
        chk("R12 ch1 still accepts", 32'(irq), 32'b011);
        rd(3'd5, d);
        chk("R12 ch1 entry", 32'(d), 32'h155);
        rd(3'd4, d);
        chk("R9 first kept", 32'(d), 32'h180);
        for (int i = 1; i < DEPTH - 1; i++) rd(3'd4, d);
        rd(3'd4, d);
        chk("R9 last kept", 32'(d), 32'h1BF);
        rd(3'd4, d);
        chk("R9 dropped not queued", 32'(d), 0);
        rd(A_STAT, d);
        chk("R9 overflow sticky", 32'(d), 32'h12A);
        wr(A_STAT, 12'h100);
        rd(A_STAT, d);
        chk("R9 overflow cleared", 32'(d), 32'h02A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_send();
        t_receive();
        t_ignore();
        t_overflow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule